// File: doc/BRIEF.md
# Translation Buffer with Page Access Checking

This block is a small fully associative cache of page translations. A lookup presents a virtual page number, an access kind (read, write or instruction fetch) and the number of the requesting process. Every stored entry is compared against the page at the same time. One clock later the block returns a registered result. The result says whether the page was found, gives the physical frame number, and gives a fault code. The code reports the most urgent problem among four: the page is absent from memory, another process owns it, it may not be executed, or it is read-only.

A miss is resolved outside the block. A page-table walker loads the missing translation through a separate refill port, together with the owner and the three permission bits. A refill fills the lowest free slot. When no slot is free, it replaces the slot chosen by a rotating pointer. A refill for a page that is already stored rewrites that slot. On a process switch a flush command empties the whole buffer in one cycle.

Top module: `tlb_guard`

## Requirements
- R1: A lookup accepted on a clock edge (`lk_req` high) produces its result one edge later with `rs_valid` high for exactly one cycle. `rs_valid` is low in every other cycle and after reset.
- R2: When no valid entry holds the requested page, the result is a miss: `rs_hit`=0, `rs_fault`=0, `rs_pfn`=0.
- R3: A refill changes the contents starting at the following cycle, so a later lookup of that page hits. A lookup in the same cycle as a refill sees the contents from before the refill.
- R4: A flush invalidates every entry and resets the rotating pointer to slot 0. A lookup in the cycle after a flush misses. If a flush and a refill arrive in the same cycle, the flush wins and the refill is dropped.
- R5: A hit on an entry whose present bit is clear reports fault code 1. This code takes priority over all other faults.
- R6: A hit on a present entry whose owner differs from `lk_pid` reports fault code 2. This code takes priority over the permission faults.
- R7: A fetch (`lk_kind`=2) from an owned, present page without execute permission reports fault code 3.
- R8: A write (`lk_kind`=1) to an owned, present page without write permission reports fault code 4. A read (`lk_kind`=0 or 3) needs no permission bit.
- R9: Every hit has `rs_hit`=1. A hit with a nonzero fault returns `rs_pfn`=0. A hit with fault 0 returns the stored frame.
- R10: A refill of a new page goes into the lowest-numbered invalid slot. If every slot is valid, it goes into the slot under the rotating pointer, and the pointer then advances by one and wraps after the last slot.
- R11: A refill of a page that is already stored overwrites that slot and leaves the other slots alone. At most one slot ever matches a page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page to translate |
| lk_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 read |
| lk_pid | input | PID_W | Requesting process |
| rf_req | input | 1 | Refill strobe from the table walker |
| rf_vpn | input | VPN_W | Virtual page being loaded |
| rf_pfn | input | PFN_W | Physical frame for that page |
| rf_pid | input | PID_W | Owning process |
| rf_wr | input | 1 | Write permitted |
| rf_ex | input | 1 | Execute permitted |
| rf_present | input | 1 | Page resident in memory |
| flush | input | 1 | Invalidate every entry |
| rs_valid | output | 1 | Result strobe |
| rs_hit | output | 1 | Page found |
| rs_pfn | output | PFN_W | Translated frame, zero on miss or fault |
| rs_fault | output | 3 | 0 none, 1 absent, 2 owner, 3 execute, 4 write |

## Verification
The checks on a single page vary the access kind and the requesting process against entries built with different permission sets. A correct frame appears only when every check passes, and each fault code can be told apart from the others. Pages that break several rules at once show that the priority order holds. Sixteen distinct refills, an overwrite, and then two more new pages show the difference between filling free slots, overwriting in place and evicting in rotation. A lookup in the same cycle as a refill, and a lookup right after a flush, pin down the timing of updates.

// File: rtl/tlb_guard_pkg.sv
package tlb_guard_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_READ2 = 2'd3
    } acc_e;

    typedef enum logic [2:0] {
        FLT_NONE   = 3'd0,
        FLT_ABSENT = 3'd1,
        FLT_OWNER  = 3'd2,
        FLT_EXEC   = 3'd3,
        FLT_WRITE  = 3'd4
    } flt_e;

    typedef struct packed {
        logic present;
        logic wr;
        logic ex;
    } perm_t;

endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter int N     = 16,
    parameter int VPN_W = 20,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]            valid,
    input  logic [N-1:0][VPN_W-1:0] tags,
    input  logic [VPN_W-1:0]        key,
    output logic                    hit,
    output logic [IDX_W-1:0]        idx,
    output logic [N-1:0]            onehot
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign onehot[g] = valid[g] && (tags[g] == key);
    end

    assign hit = |onehot;

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (onehot[i]) idx = idx | IDX_W'(i);
        end
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int N = 16,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     valid,
    input  logic [IDX_W-1:0] ptr,
    output logic             use_ptr,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        use_ptr = 1'b1;
        idx     = ptr;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                use_ptr = 1'b0;
                idx     = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tlb_perm.sv
module tlb_perm
    import tlb_guard_pkg::*;
#(
    parameter int PID_W = 8
) (
    input  perm_t            perm,
    input  logic [PID_W-1:0] owner,
    input  logic [PID_W-1:0] pid,
    input  logic [1:0]       kind,
    output logic [2:0]       fault
);
    acc_e acc;
    flt_e code;

    always_comb begin
        acc = acc_e'(kind);
        if (!perm.present)                      code = FLT_ABSENT;
        else if (owner != pid)                  code = FLT_OWNER;
        else if (acc == ACC_EXEC && !perm.ex)   code = FLT_EXEC;
        else if (acc == ACC_WRITE && !perm.wr)  code = FLT_WRITE;
        else                                    code = FLT_NONE;
        fault = code;
    end
endmodule

// File: rtl/tlb_guard.sv
module tlb_guard
    import tlb_guard_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 16,
    parameter int PID_W   = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_req,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [1:0]       lk_kind,
    input  logic [PID_W-1:0] lk_pid,
    input  logic             rf_req,
    input  logic [VPN_W-1:0] rf_vpn,
    input  logic [PFN_W-1:0] rf_pfn,
    input  logic [PID_W-1:0] rf_pid,
    input  logic             rf_wr,
    input  logic             rf_ex,
    input  logic             rf_present,
    input  logic             flush,
    output logic             rs_valid,
    output logic             rs_hit,
    output logic [PFN_W-1:0] rs_pfn,
    output logic [2:0]       rs_fault
);
    typedef struct packed {
        logic             valid;
        logic [VPN_W-1:0] vpn;
        logic [PFN_W-1:0] pfn;
        logic [PID_W-1:0] owner;
        perm_t            perm;
    } entry_t;

    typedef struct packed {
        entry_t [ENTRIES-1:0] tab;
        logic [IDX_W-1:0]     rr;
        logic                 rs_valid;
        logic                 rs_hit;
        logic [PFN_W-1:0]     rs_pfn;
        logic [2:0]           rs_fault;
    } state_t;

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    state_t st_d, st_q;

    logic [ENTRIES-1:0]            valid_v;
    logic [ENTRIES-1:0][VPN_W-1:0] tag_v;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_flat
        assign valid_v[g] = st_q.tab[g].valid;
        assign tag_v[g]   = st_q.tab[g].vpn;
    end

    logic             lk_hit, rf_hit, use_ptr;
    logic [IDX_W-1:0] lk_idx, rf_idx, fill_idx;
    logic [ENTRIES-1:0] lk_onehot, rf_onehot;
    logic [2:0]       lk_fault;
    entry_t           lk_ent;

    tlb_match #(.N(ENTRIES), .VPN_W(VPN_W)) u_lk_match (
        .valid(valid_v), .tags(tag_v), .key(lk_vpn),
        .hit(lk_hit), .idx(lk_idx), .onehot(lk_onehot)
    );

    tlb_match #(.N(ENTRIES), .VPN_W(VPN_W)) u_rf_match (
        .valid(valid_v), .tags(tag_v), .key(rf_vpn),
        .hit(rf_hit), .idx(rf_idx), .onehot(rf_onehot)
    );

    tlb_victim #(.N(ENTRIES)) u_victim (
        .valid(valid_v), .ptr(st_q.rr), .use_ptr(use_ptr), .idx(fill_idx)
    );

    assign lk_ent = st_q.tab[lk_idx];

    tlb_perm #(.PID_W(PID_W)) u_perm (
        .perm(lk_ent.perm), .owner(lk_ent.owner), .pid(lk_pid),
        .kind(lk_kind), .fault(lk_fault)
    );

    always_comb begin
        logic [IDX_W-1:0] wr_idx;
        st_d     = st_q;
        wr_idx   = fill_idx;

        st_d.rs_valid = lk_req;
        st_d.rs_hit   = lk_req && lk_hit;
        st_d.rs_fault = (lk_req && lk_hit) ? lk_fault : 3'd0;
        st_d.rs_pfn   = (lk_req && lk_hit && lk_fault == 3'd0) ? lk_ent.pfn : '0;

        if (flush) begin
            for (int i = 0; i < ENTRIES; i++) st_d.tab[i].valid = 1'b0;
            st_d.rr = '0;
        end else if (rf_req) begin
            if (rf_hit) begin
                wr_idx = rf_idx;
            end else if (use_ptr) begin
                wr_idx  = st_q.rr;
                st_d.rr = (st_q.rr == LAST) ? '0 : st_q.rr + 1'b1;
            end
            st_d.tab[wr_idx].valid        = 1'b1;
            st_d.tab[wr_idx].vpn          = rf_vpn;
            st_d.tab[wr_idx].pfn          = rf_pfn;
            st_d.tab[wr_idx].owner        = rf_pid;
            st_d.tab[wr_idx].perm.present = rf_present;
            st_d.tab[wr_idx].perm.wr      = rf_wr;
            st_d.tab[wr_idx].perm.ex      = rf_ex;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rs_valid = st_q.rs_valid;
    assign rs_hit   = st_q.rs_hit;
    assign rs_pfn   = st_q.rs_pfn;
    assign rs_fault = st_q.rs_fault;
endmodule

// File: rtl/tlb_guard_chk.sv
module tlb_guard_chk #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_req,
    input logic [VPN_W-1:0]   lk_vpn,
    input logic               rf_req,
    input logic [VPN_W-1:0]   rf_vpn,
    input logic               flush,
    input logic               rs_valid,
    input logic               rs_hit,
    input logic [PFN_W-1:0]   rs_pfn,
    input logic [2:0]         rs_fault,
    input logic [ENTRIES-1:0] lk_onehot,
    input logic [ENTRIES-1:0] rf_onehot
);
    p_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rs_valid);
    p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !rs_valid);
    p_miss_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && !rs_hit) |-> (rs_fault == 3'd0 && rs_pfn == '0));
    p_refill_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_req && !flush) ##1 (lk_req && lk_vpn == $past(rf_vpn)) |=> rs_hit);
    p_flush_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flush ##1 lk_req |=> !rs_hit);
    p_code_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rs_valid |-> rs_fault <= 3'd4);
    p_fault_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && rs_fault != 3'd0) |-> (rs_hit && rs_pfn == '0));
    p_single_lk_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_onehot));
    p_single_rf_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rf_onehot));
endmodule

bind tlb_guard tlb_guard_chk #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vpn(lk_vpn),
    .rf_req(rf_req), .rf_vpn(rf_vpn), .flush(flush),
    .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_pfn(rs_pfn), .rs_fault(rs_fault),
    .lk_onehot(lk_onehot), .rf_onehot(rf_onehot)
);

// File: tb/sim_tlb_guard.sv
module sim_tlb_guard;
    localparam int N = 16;
    localparam int VW = 20;
    localparam int FW = 16;
    localparam int PW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lk_req = 0, rf_req = 0, flush = 0;
    logic [VW-1:0] lk_vpn = '0, rf_vpn = '0;
    logic [1:0] lk_kind = '0;
    logic [PW-1:0] lk_pid = '0, rf_pid = '0;
    logic [FW-1:0] rf_pfn = '0;
    logic rf_wr = 0, rf_ex = 0, rf_present = 0;
    logic rs_valid, rs_hit;
    logic [FW-1:0] rs_pfn;
    logic [2:0] rs_fault;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic          hit;
        logic [2:0]    fault;
        logic [FW-1:0] pfn;
        string         tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    tlb_guard #(.ENTRIES(N), .VPN_W(VW), .PFN_W(FW), .PID_W(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vpn(lk_vpn),
        .lk_kind(lk_kind), .lk_pid(lk_pid), .rf_req(rf_req), .rf_vpn(rf_vpn),
        .rf_pfn(rf_pfn), .rf_pid(rf_pid), .rf_wr(rf_wr), .rf_ex(rf_ex),
        .rf_present(rf_present), .flush(flush), .rs_valid(rs_valid),
        .rs_hit(rs_hit), .rs_pfn(rs_pfn), .rs_fault(rs_fault)
    );

    // monitor: compares each result strobe against the scoreboard head
    always @(negedge clk) begin
        if (rst_n && !done && rs_valid) begin
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL R1 unexpected result strobe: actual 1 expected 0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (rs_hit !== e.hit || rs_fault !== e.fault || rs_pfn !== e.pfn) begin
                    errors++;
                    $display("FAIL %s actual hit=%0d fault=%0d pfn=%h expected hit=%0d fault=%0d pfn=%h",
                             e.tag, rs_hit, rs_fault, rs_pfn, e.hit, e.fault, e.pfn);
                end
            end
        end
    end

    task automatic lookup(input logic [VW-1:0] v, input logic [1:0] k, input logic [PW-1:0] p,
                          input logic eh, input logic [2:0] ef, input logic [FW-1:0] ep,
                          input string tag);
        exp_t e;
        e.hit = eh; e.fault = ef; e.pfn = ep; e.tag = tag;
        sb.push_back(e);
        lk_req = 1; lk_vpn = v; lk_kind = k; lk_pid = p;
        @(posedge clk); #2;
        lk_req = 0;
    endtask

    task automatic load(input logic [VW-1:0] v, input logic [FW-1:0] f, input logic [PW-1:0] p,
                        input logic w, input logic x, input logic pr);
        rf_req = 1; rf_vpn = v; rf_pfn = f; rf_pid = p; rf_wr = w; rf_ex = x; rf_present = pr;
        @(posedge clk); #2;
        rf_req = 0;
    endtask

    task automatic load_and_look(input logic [VW-1:0] v, input logic [FW-1:0] f,
                                 input logic [PW-1:0] p);
        exp_t e;
        e.hit = 0; e.fault = 0; e.pfn = '0; e.tag = "R3 same-cycle lookup sees old contents";
        sb.push_back(e);
        rf_req = 1; rf_vpn = v; rf_pfn = f; rf_pid = p; rf_wr = 1; rf_ex = 1; rf_present = 1;
        lk_req = 1; lk_vpn = v; lk_kind = 2'd0; lk_pid = p;
        @(posedge clk); #2;
        rf_req = 0; lk_req = 0;
    endtask

    task automatic do_flush();
        flush = 1;
        @(posedge clk); #2;
        flush = 0;
    endtask

    task automatic finish_run();
        done = 1;
        if (sb.size() != 0) begin
            checks++; errors++;
            $display("FAIL R1 missing results: actual %0d pending expected 0", sb.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R1 watchdog expired: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        @(negedge clk);
        checks++;
        if (rs_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset strobe: actual %0d expected 0", rs_valid);
        end
        @(posedge clk); #2;

        lookup(20'h100, 2'd0, 8'd3, 0, 3'd0, 16'h0, "R2 empty buffer misses");
        load(20'h100, 16'h2A, 8'd3, 1, 0, 1);
        lookup(20'h100, 2'd0, 8'd3, 1, 3'd0, 16'h2A, "R3 read hit after refill");
        lookup(20'h100, 2'd1, 8'd3, 1, 3'd0, 16'h2A, "R8 write allowed");
        lookup(20'h100, 2'd2, 8'd3, 1, 3'd3, 16'h0, "R7 fetch without execute");
        lookup(20'h100, 2'd0, 8'd5, 1, 3'd2, 16'h0, "R6 owner mismatch");
        lookup(20'h100, 2'd2, 8'd5, 1, 3'd2, 16'h0, "R6 owner beats execute");
        load(20'h200, 16'h3B, 8'd3, 0, 1, 1);
        lookup(20'h200, 2'd1, 8'd3, 1, 3'd4, 16'h0, "R8 write to read-only");
        lookup(20'h200, 2'd2, 8'd3, 1, 3'd0, 16'h3B, "R9 fetch allowed returns frame");
        lookup(20'h200, 2'd3, 8'd3, 1, 3'd0, 16'h3B, "R8 kind 3 reads freely");
        load(20'h300, 16'h4C, 8'd7, 0, 0, 0);
        lookup(20'h300, 2'd2, 8'd1, 1, 3'd1, 16'h0, "R5 absent beats all");
        lookup(20'h300, 2'd0, 8'd7, 1, 3'd1, 16'h0, "R5 absent on read");
        load(20'h100, 16'h55, 8'd3, 1, 0, 1);
        lookup(20'h100, 2'd0, 8'd3, 1, 3'd0, 16'h55, "R11 overwrite updates frame");
        load_and_look(20'h400, 16'h66, 8'd3);
        lookup(20'h400, 2'd0, 8'd3, 1, 3'd0, 16'h66, "R3 hit one cycle later");
        do_flush();
        lookup(20'h100, 2'd0, 8'd3, 0, 3'd0, 16'h0, "R4 miss right after flush");
        lookup(20'h400, 2'd0, 8'd3, 0, 3'd0, 16'h0, "R4 all entries cleared");

        for (int i = 0; i < N; i++) load(VW'(32'h1000 + i), FW'(32'h10 + i), 8'd2, 1, 1, 1);
        load(20'h1000, 16'h99, 8'd2, 1, 1, 1);
        lookup(20'h1000, 2'd0, 8'd2, 1, 3'd0, 16'h99, "R11 rewrite in place");
        lookup(20'h100F, 2'd0, 8'd2, 1, 3'd0, 16'h1F, "R11 last slot kept");
        load(20'h2000, 16'h77, 8'd2, 1, 1, 1);
        lookup(20'h1000, 2'd0, 8'd2, 0, 3'd0, 16'h0, "R10 pointer evicts slot 0");
        lookup(20'h1001, 2'd0, 8'd2, 1, 3'd0, 16'h11, "R10 slot 1 kept");
        lookup(20'h2000, 2'd0, 8'd2, 1, 3'd0, 16'h77, "R10 new page resident");
        load(20'h3000, 16'h78, 8'd2, 1, 1, 1);
        lookup(20'h1001, 2'd0, 8'd2, 0, 3'd0, 16'h0, "R10 pointer advanced to slot 1");
        lookup(20'h1002, 2'd0, 8'd2, 1, 3'd0, 16'h12, "R10 slot 2 kept");

        flush = 1; rf_req = 1; rf_vpn = 20'h5000; rf_pfn = 16'h5; rf_pid = 8'd2;
        rf_wr = 1; rf_ex = 1; rf_present = 1;
        @(posedge clk); #2;
        flush = 0; rf_req = 0;
        lookup(20'h5000, 2'd0, 8'd2, 0, 3'd0, 16'h0, "R4 flush drops same-cycle refill");

        repeat (3) @(posedge clk);
        #2 finish_run();
    end
endmodule